// File: doc/BRIEF.md
# Register Window Pointer Controller

This block holds the current window pointer of a processor whose register file is arranged as a ring of overlapping windows. The number of windows is a parameter and need not be a power of two. The pipeline issues one request per cycle: move the pointer down one window (save), move it up one window (restore), return from a trap, or write the processor status word. Each pointer move is checked against an externally held window-invalid mask. A move into a masked window raises a trap pulse in place of the move.

The block also keeps the processor status word. That word carries the condition codes, the floating-point enable, the interrupt level, the supervisor and previous-supervisor flags, the trap-enable flag and the window pointer. The block presents the word packed and loads it back from a write. The register file and the trap vectoring logic live outside. They read the pointer, the status word and the three trap pulses.

Top module: `wpc_ctrl`

## Requirements
- R1: After reset the window pointer is 0, the supervisor flag is 1, every other status field is 0, and no trap output is high.
- R2: Pointer arithmetic is modulo NWIN. Restore from window NWIN-1 targets window 0, and save from window 0 targets window NWIN-1.
- R3: A save (req_kind 2'b00) targets pointer-1. If that window's bit in win_invalid is 1, trap_overflow pulses and no state changes. Otherwise the pointer takes the target.
- R4: A restore (req_kind 2'b01) targets pointer+1. If that window's bit is 1, trap_underflow pulses and no state changes. Otherwise the pointer takes the target.
- R5: A return from trap (req_kind 2'b10) while trap-enable is 1 pulses trap_illegal and changes no state.
- R6: A return from trap while trap-enable is 0 sets trap-enable to 1 and targets pointer+1. If that window is masked, trap_underflow pulses and the pointer and supervisor flag keep their values. Otherwise the pointer moves and the supervisor flag takes the previous-supervisor value.
- R7: A status write (req_kind 2'b11) whose bits 4:0 are NWIN or more pulses trap_illegal and changes no state.
- R8: A valid status write loads the following fields from req_wdata: condition codes 23:20, FP enable 12, interrupt level 11:8, supervisor 7, previous supervisor 6, trap enable 5 and pointer 4:0. All other bits are ignored.
- R9: status_word carries VERSION at 31:24 and the current fields at the positions listed in R8. Bits 19:13 read 0.
- R10: Results are registered and appear one clock after the request. Each trap output is high for exactly that one cycle unless the next request also traps. At most one trap output is high at a time.
- R11: With req_valid low, the block ignores req_kind, req_wdata and win_invalid. No state changes and no trap pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 2 | 00 save, 01 restore, 10 return from trap, 11 status write |
| req_wdata | input | 32 | New status word for a status write |
| win_invalid | input | 32 | Per-window invalid mask; bit k guards window k |
| cwp | output | 5 | Current window pointer |
| status_word | output | 32 | Packed processor status word |
| trap_overflow | output | 1 | One-cycle pulse: save hit a masked window |
| trap_underflow | output | 1 | One-cycle pulse: restore or return hit a masked window |
| trap_illegal | output | 1 | One-cycle pulse: bad return from trap or out-of-range status write |

## Verification
The bench builds the block with NWIN = 6 and VERSION = 8'hA5. The window count is not a power of two, so the wrap runs through the compare-and-reload path and not through plain truncation. At six windows the bench can sweep every starting pointer against all 64 mask patterns for save, restore and return from trap, with trap-enable both set and clear. It can also sweep every 5-bit pointer value a status write can carry, which covers the invalid values 6 to 31. Garbage is placed in the ignored word bits, in the mask bits above window 5, and on the request lines while req_valid is low.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

   localparam int CWP_W   = 5;
   localparam int WORD_W  = 32;
   localparam int MASK_W  = 32;

   localparam int BIT_VER_LO = 24;
   localparam int BIT_ICC_LO = 20;
   localparam int BIT_EF     = 12;
   localparam int BIT_PIL_LO = 8;
   localparam int BIT_S      = 7;
   localparam int BIT_PS     = 6;
   localparam int BIT_ET     = 5;

   typedef enum logic [1:0] {
      RQ_SAVE    = 2'b00,
      RQ_RESTORE = 2'b01,
      RQ_RETT    = 2'b10,
      RQ_WRSTAT  = 2'b11
   } req_kind_e;

   typedef struct packed {
      logic [3:0]       icc;
      logic             ef;
      logic [3:0]       pil;
      logic             s;
      logic             ps;
      logic             et;
      logic [CWP_W-1:0] cwp;
   } stat_t;

endpackage

// File: rtl/wpc_wrap_step.sv
module wpc_wrap_step
   import wpc_pkg::*;
#(
   parameter int NWIN = 8
) (
   input  logic [CWP_W-1:0] cur,
   output logic [CWP_W-1:0] up,
   output logic [CWP_W-1:0] down
);

   localparam logic [CWP_W-1:0] LAST   = CWP_W'(NWIN - 1);
   localparam bit               IS_POW2 = ((NWIN & (NWIN - 1)) == 0);

   generate
      if (IS_POW2) begin : g_pow2
         // Ring size is a power of two: truncation does the wrap.
         assign up   = (cur + CWP_W'(1)) & LAST;
         assign down = (cur - CWP_W'(1)) & LAST;
      end else begin : g_mod
         // Arbitrary ring size: compare at the ends and reload.
         assign up   = (cur == LAST)       ? '0   : cur + CWP_W'(1);
         assign down = (cur == '0)         ? LAST : cur - CWP_W'(1);
      end
   endgenerate

endmodule

// File: rtl/wpc_mask_probe.sv
module wpc_mask_probe
   import wpc_pkg::*;
#(
   parameter int NWIN = 8
) (
   input  logic [MASK_W-1:0] mask,
   input  logic [CWP_W-1:0]  idx_up,
   input  logic [CWP_W-1:0]  idx_down,
   output logic              hit_up,
   output logic              hit_down
);

   logic [NWIN-1:0] sel_up;
   logic [NWIN-1:0] sel_down;

   genvar k;
   generate
      for (k = 0; k < NWIN; k++) begin : g_win
         assign sel_up[k]   = mask[k] && (idx_up   == CWP_W'(k));
         assign sel_down[k] = mask[k] && (idx_down == CWP_W'(k));
      end
      if (NWIN < MASK_W) begin : g_spare
         logic unused_hi;
         assign unused_hi = ^mask[MASK_W-1:NWIN];
      end
   endgenerate

   assign hit_up   = |sel_up;
   assign hit_down = |sel_down;

endmodule

// File: rtl/wpc_status_fmt.sv
module wpc_status_fmt
   import wpc_pkg::*;
#(
   parameter logic [7:0] VERSION = 8'h00
) (
   input  stat_t              fields_in,
   output logic [WORD_W-1:0]  word_out,
   input  logic [WORD_W-1:0]  word_in,
   output stat_t              fields_out
);

   always_comb begin
      word_out                            = '0;
      word_out[BIT_VER_LO +: 8]           = VERSION;
      word_out[BIT_ICC_LO +: 4]           = fields_in.icc;
      word_out[BIT_EF]                    = fields_in.ef;
      word_out[BIT_PIL_LO +: 4]           = fields_in.pil;
      word_out[BIT_S]                     = fields_in.s;
      word_out[BIT_PS]                    = fields_in.ps;
      word_out[BIT_ET]                    = fields_in.et;
      word_out[CWP_W-1:0]                 = fields_in.cwp;
   end

   always_comb begin
      fields_out.icc = word_in[BIT_ICC_LO +: 4];
      fields_out.ef  = word_in[BIT_EF];
      fields_out.pil = word_in[BIT_PIL_LO +: 4];
      fields_out.s   = word_in[BIT_S];
      fields_out.ps  = word_in[BIT_PS];
      fields_out.et  = word_in[BIT_ET];
      fields_out.cwp = word_in[CWP_W-1:0];
   end

   logic unused_bits;
   assign unused_bits = ^{word_in[WORD_W-1:BIT_ICC_LO+4], word_in[BIT_ICC_LO-1:BIT_EF+1]};

endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
   import wpc_pkg::*;
#(
   parameter int         NWIN    = 8,
   parameter logic [7:0] VERSION = 8'h00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [1:0]  req_kind,
   input  logic [31:0] req_wdata,
   input  logic [31:0] win_invalid,
   output logic [4:0]  cwp,
   output logic [31:0] status_word,
   output logic        trap_overflow,
   output logic        trap_underflow,
   output logic        trap_illegal
);

   generate
      if (NWIN < 2 || NWIN > (1 << CWP_W)) begin : g_bad_nwin
         $fatal(1, "wpc_ctrl: NWIN must lie in 2..32");
      end
   endgenerate

   localparam stat_t RESET_STAT = '{icc: '0, ef: 1'b0, pil: '0, s: 1'b1,
                                    ps: 1'b0, et: 1'b0, cwp: '0};

   stat_t            cur_q, nxt;
   stat_t            wr_fields;
   logic [CWP_W-1:0] tgt_up, tgt_down;
   logic             blk_up, blk_down;
   logic             wr_ok;
   logic             ovf_d, unf_d, ill_d;
   logic             ovf_q, unf_q, ill_q;
   req_kind_e        kind;

   assign kind = req_kind_e'(req_kind);

   wpc_wrap_step #(.NWIN(NWIN)) u_step (
      .cur  (cur_q.cwp),
      .up   (tgt_up),
      .down (tgt_down)
   );

   wpc_mask_probe #(.NWIN(NWIN)) u_probe (
      .mask     (win_invalid),
      .idx_up   (tgt_up),
      .idx_down (tgt_down),
      .hit_up   (blk_up),
      .hit_down (blk_down)
   );

   wpc_status_fmt #(.VERSION(VERSION)) u_fmt (
      .fields_in  (cur_q),
      .word_out   (status_word),
      .word_in    (req_wdata),
      .fields_out (wr_fields)
   );

   assign wr_ok = (req_wdata[CWP_W-1:0] < CWP_W'(NWIN - 1)) ||
                  (req_wdata[CWP_W-1:0] == CWP_W'(NWIN - 1));

   always_comb begin
      nxt   = cur_q;
      ovf_d = 1'b0;
      unf_d = 1'b0;
      ill_d = 1'b0;
      if (req_valid) begin
         unique case (kind)
            RQ_SAVE: begin
               if (blk_down) ovf_d = 1'b1;
               else          nxt.cwp = tgt_down;
            end
            RQ_RESTORE: begin
               if (blk_up) unf_d = 1'b1;
               else        nxt.cwp = tgt_up;
            end
            RQ_RETT: begin
               if (cur_q.et) begin
                  ill_d = 1'b1;
               end else begin
                  nxt.et = 1'b1;
                  if (blk_up) begin
                     unf_d = 1'b1;
                  end else begin
                     nxt.cwp = tgt_up;
                     nxt.s   = cur_q.ps;
                  end
               end
            end
            RQ_WRSTAT: begin
               if (wr_ok) nxt   = wr_fields;
               else       ill_d = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= RESET_STAT;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
         ill_q <= 1'b0;
      end else begin
         cur_q <= nxt;
         ovf_q <= ovf_d;
         unf_q <= unf_d;
         ill_q <= ill_d;
      end
   end

   assign cwp            = cur_q.cwp;
   assign trap_overflow  = ovf_q;
   assign trap_underflow = unf_q;
   assign trap_illegal   = ill_q;

   // R2: pointer never leaves the ring
   a_r2_cwp_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      cwp < CWP_W'(NWIN - 1) || cwp == CWP_W'(NWIN - 1));

   // R3: overflow leaves the pointer where it was
   a_r3_ovf_holds_cwp: assert property (@(posedge clk) disable iff (!rst_n)
      trap_overflow |-> $stable(cwp));

   // R4: underflow from a restore leaves the whole word alone
   a_r4_unf_holds_word: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_underflow && $past(req_kind) == 2'b01) |-> $stable(status_word));

   // R5: illegal return changes nothing
   a_r5_bad_rett_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_illegal && $past(req_kind) == 2'b10) |-> $stable(status_word));

   // R6: any accepted return leaves trap enable set
   a_r6_rett_sets_et: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && req_kind == 2'b10) |-> status_word[BIT_ET]);

   // R7: rejected status write changes nothing
   a_r7_bad_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_illegal && $past(req_kind) == 2'b11) |-> $stable(status_word));

   // R10: trap outputs are mutually exclusive
   a_r10_one_trap: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({trap_overflow, trap_underflow, trap_illegal}));

   // R11: idle cycles leave state alone and raise no trap
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid) |-> ($stable(status_word) &&
                             !(trap_overflow || trap_underflow || trap_illegal)));

endmodule

// File: tb/sim_wpc_ctrl.sv
module sim_wpc_ctrl;

   localparam int         NW  = 6;
   localparam logic [7:0] VER = 8'hA5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'b00;
   logic [31:0] req_wdata = '0;
   logic [31:0] win_invalid = '0;
   logic [4:0]  cwp;
   logic [31:0] status_word;
   logic        trap_overflow, trap_underflow, trap_illegal;

   int nvec = 0;
   int nbad = 0;
   bit done = 0;

   // model state
   int       m_cwp;
   bit [3:0] m_icc, m_pil;
   bit       m_ef, m_s, m_ps, m_et;

   always #10 clk = ~clk;

   wpc_ctrl #(.NWIN(NW), .VERSION(VER)) u0 (
      .clk, .rst_n, .req_valid, .req_kind, .req_wdata, .win_invalid,
      .cwp, .status_word, .trap_overflow, .trap_underflow, .trap_illegal
   );

   function automatic logic [31:0] exp_word();
      logic [31:0] w;
      w        = '0;
      w[31:24] = VER;
      w[23:20] = m_icc;
      w[12]    = m_ef;
      w[11:8]  = m_pil;
      w[7]     = m_s;
      w[6]     = m_ps;
      w[5]     = m_et;
      w[4:0]   = 5'(m_cwp);
      return w;
   endfunction

   // Caller is at a falling edge; result sampled at the next falling edge.
   task automatic apply(input bit v, input bit [1:0] k, input logic [31:0] d,
                        input logic [31:0] msk, input string tag);
      bit ov, un, il;
      int t;
      logic [31:0] ew;
      ov = 0; un = 0; il = 0;
      req_valid = v; req_kind = k; req_wdata = d; win_invalid = msk;
      if (v) begin
         case (k)
            2'b00: begin
               t = (m_cwp == 0) ? NW - 1 : m_cwp - 1;
               if (msk[t]) ov = 1; else m_cwp = t;
            end
            2'b01: begin
               t = (m_cwp == NW - 1) ? 0 : m_cwp + 1;
               if (msk[t]) un = 1; else m_cwp = t;
            end
            2'b10: begin
               if (m_et) il = 1;
               else begin
                  m_et = 1;
                  t = (m_cwp == NW - 1) ? 0 : m_cwp + 1;
                  if (msk[t]) un = 1;
                  else begin m_cwp = t; m_s = m_ps; end
               end
            end
            default: begin
               if (int'(d[4:0]) >= NW) il = 1;
               else begin
                  m_icc = d[23:20]; m_ef = d[12]; m_pil = d[11:8];
                  m_s = d[7]; m_ps = d[6]; m_et = d[5]; m_cwp = int'(d[4:0]);
               end
            end
         endcase
      end
      ew = exp_word();
      @(negedge clk);
      nvec++;
      if (status_word !== ew || cwp !== ew[4:0] ||
          {trap_overflow, trap_underflow, trap_illegal} !== {ov, un, il}) begin
         nbad++;
         $display("FAIL %s (R9 R10): word=%h traps=%b expected word=%h traps=%b",
                  tag, status_word, {trap_overflow, trap_underflow, trap_illegal},
                  ew, {ov, un, il});
      end
   endtask

   function automatic logic [31:0] mk_word(int c, bit [3:0] icc, bit ef,
                                           bit [3:0] pil, bit s, bit ps, bit et);
      logic [31:0] w;
      w        = 32'h3C_0_FE_000;   // garbage in ignored bits (R8)
      w[23:20] = icc;
      w[12]    = ef;
      w[11:8]  = pil;
      w[7]     = s;
      w[6]     = ps;
      w[5]     = et;
      w[4:0]   = 5'(c);
      return w;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      m_cwp = 0; m_icc = 0; m_pil = 0; m_ef = 0; m_s = 1; m_ps = 0; m_et = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      nvec++;
      if (status_word !== exp_word() || cwp !== 5'd0 ||
          {trap_overflow, trap_underflow, trap_illegal} !== 3'b000) begin
         nbad++;
         $display("FAIL R1: word=%h expected %h", status_word, exp_word());
      end

      // Sweep every start window, every mask pattern, each move kind
      for (int c = 0; c < NW; c++) begin
         for (int m = 0; m < 64; m++) begin
            for (int k = 0; k < 3; k++) begin
               bit et0;
               string tg;
               logic [31:0] msk;
               et0 = (k == 2) ? (m % 3 == 0) : bit'(m[1]);
               apply(1, 2'b11,
                     mk_word(c, 4'(m), bit'(m[4]), 4'(c + m), bit'(m[2]),
                             bit'(m[3]), et0),
                     32'hFFFF_FFFF, "R8");
               msk = {26'h2AA_AAAA, 6'(m)};   // bits above window 5 are junk
               if (k == 0)      tg = (c == 0)      ? "R2" : "R3";
               else if (k == 1) tg = (c == NW - 1) ? "R2" : "R4";
               else             tg = et0 ? "R5" : "R6";
               apply(1, 2'(k), 32'hDEAD_BEEF, msk, tg);
               apply(0, 2'(2 - k), 32'h0000_001F, ~msk, "R11");
            end
         end
      end

      // Every pointer value a status write can carry, valid and invalid
      for (int c = 0; c < 32; c++) begin
         apply(1, 2'b11, mk_word(c, 4'(c), bit'(c & 1), 4'(~c), bit'(c >> 1),
                                 bit'(c >> 2), bit'(c >> 3)),
               '0, (c >= NW) ? "R7" : "R8");
         apply(0, 2'b11, 32'h0000_001F, '1, "R11");
      end

      // Back-to-back traps keep pulsing; a following idle clears them
      apply(1, 2'b11, mk_word(2, 4'h5, 1, 4'h3, 1, 0, 1), '0, "R8");
      apply(1, 2'b10, '0, '0, "R5");
      apply(1, 2'b10, '0, '0, "R5");
      apply(1, 2'b00, '0, 32'h0000_0002, "R3");
      apply(1, 2'b01, '0, 32'h0000_0008, "R4");
      apply(0, 2'b00, '0, '0, "R10");
      // Walk all the way round the ring in both directions
      for (int i = 0; i < 2 * NW; i++) apply(1, 2'b01, '0, '0, "R2");
      for (int i = 0; i < 2 * NW; i++) apply(1, 2'b00, '0, '0, "R2");

      req_valid = 1'b0;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule